// File: doc/BRIEF.md
# Alarm-Triggered Power-Enable Sequencer

This block sits beside a real-time clock and drives the enable line of an external power-management chip. Once alarm-based power control is switched on in its control register, a match pulse from the clock's secondary alarm comparator turns the enable line off, so the system can cut its own supply at a preset time. The block also latches a sticky flag for that alarm and raises an interrupt when the flag is set and the interrupt is enabled.

To power back up, up to four external wake lines are watched. Each line has its own enable bit and its own polarity bit in the control register. The lines pass through a synchronizer. When an enabled line reaches its active level while power is off, the enable output returns high and a one-cycle wake-request pulse is issued. The alarm comparator and any debouncing of the wake lines are outside this block. A bus decoder outside the block turns a status write that carries a 1 in bit 7 into the single-cycle clear strobe.

Top module: `pwr_alarm_seq`

## Requirements
- R1: After reset the power-enable output is high, the wake-request output and the alarm flag are low, and the control readback is 0x000000F0: every wake line is disabled and set to active-low.
- R2: A control write takes effect on the next clock edge. Bits 0..3 (wake enables), bits 4..7 (wake polarity) and bit 16 (alarm power control) are stored. Every other bit reads back as 0.
- R3: If bit 16 is set and power is on, an alarm match pulse turns the power-enable output off on the next clock edge.
- R4: If bit 16 is clear, an alarm match pulse leaves the power-enable output unchanged.
- R5: An alarm match pulse sets the alarm flag on the next edge. The flag holds until a clear strobe (a status write with bit 7 = 1) arrives without a match in the same cycle. When a match and a clear arrive together, the match wins.
- R6: The interrupt output is high in exactly those cycles in which both the alarm flag and the interrupt-enable input (interrupt-enable bit 4, supplied by the bus side) are high.
- R7: Wake line i is active when its enable bit i is set and its level matches its polarity bit 4+i: a set polarity bit means active when the line is 0, a clear bit means active when the line is 1. While power is off, an active line turns power on SYNC_STAGES+1 edges after the line changes. In that same cycle the wake-request output is high, for exactly one cycle.
- R8: A wake line whose enable bit is clear, or whose level is the inactive one, never turns power on.
- R9: While power is on, an active wake line causes no wake-request pulse and no change of the power-enable output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 32 | Control register write data |
| cfg_rdata | output | 32 | Control register readback |
| alarm_b_clr | input | 1 | Clear strobe for the alarm flag (status write with bit 7 set) |
| alarm_b_hit | input | 1 | One-cycle match pulse from the secondary alarm comparator |
| alarm_b_ie | input | 1 | Interrupt enable for the secondary alarm |
| wake_in | input | 4 | Asynchronous external wake lines |
| pwr_en_o | output | 1 | Power-enable line to the external power chip, high = on |
| wake_req_o | output | 1 | One-cycle pulse when a wake line restores power |
| alarm_b_flag_o | output | 1 | Sticky alarm flag |
| alarm_b_irq_o | output | 1 | Alarm interrupt request |

## Verification
The control readback, the alarm flag and the alarm-driven turn-off each change on the first rising edge after their stimulus. The interrupt output follows the flag and the enable input within the same cycle. A wake line takes SYNC_STAGES+1 rising edges to restore power, and the wake-request pulse lasts exactly one cycle after that. The bench drives every input on a falling edge and then counts falling edges, one per rising edge crossed, before it samples. Each result is therefore read half a period after the edge that should have produced it, and the bench also reads it on the following cycle to confirm that it holds or, for the pulse, that it has dropped.

// File: rtl/pwr_alarm_pkg.sv
`timescale 1ns/1ps
package pwr_alarm_pkg;

  localparam int CTRL_W      = 32;
  localparam int PWR_CTL_BIT = 16;

  typedef enum logic {
    PWR_OFF = 1'b0,
    PWR_ON  = 1'b1
  } pwr_state_e;

  // Writable control bits: enables [n-1:0], polarities [2n-1:n], power control.
  function automatic logic [CTRL_W-1:0] ctrl_mask(input int n_wake);
    logic [CTRL_W-1:0] m;
    m = '0;
    for (int i = 0; i < 2 * n_wake; i++) m[i] = 1'b1;
    m[PWR_CTL_BIT] = 1'b1;
    return m;
  endfunction

  // Reset value: every wake line disabled and set to active-low.
  function automatic logic [CTRL_W-1:0] ctrl_reset(input int n_wake);
    logic [CTRL_W-1:0] r;
    r = '0;
    for (int i = n_wake; i < 2 * n_wake; i++) r[i] = 1'b1;
    return r;
  endfunction

endpackage

// File: rtl/pwr_wake_sync.sv
`timescale 1ns/1ps
module pwr_wake_sync #(
  parameter int N_WAKE      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_WAKE-1:0] wake_async,
  output logic [N_WAKE-1:0] wake_sync
);

  for (genvar g = 0; g < N_WAKE; g++) begin : g_line
    if (SYNC_STAGES > 1) begin : g_chain
      logic [SYNC_STAGES-1:0] sr;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= '0;
        else        sr <= {sr[SYNC_STAGES-2:0], wake_async[g]};
      end
      assign wake_sync[g] = sr[SYNC_STAGES-1];
    end else begin : g_single
      logic sr1;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr1 <= 1'b0;
        else        sr1 <= wake_async[g];
      end
      assign wake_sync[g] = sr1;
    end
  end

endmodule

// File: rtl/pwr_ctrl_regs.sv
`timescale 1ns/1ps
module pwr_ctrl_regs
  import pwr_alarm_pkg::*;
#(
  parameter int N_WAKE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [CTRL_W-1:0] cfg_wdata,
  input  logic              alarm_b_hit,
  input  logic              flag_clr,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              alarm_flag
);

  localparam logic [CTRL_W-1:0] MASK = ctrl_mask(N_WAKE);
  localparam logic [CTRL_W-1:0] RST  = ctrl_reset(N_WAKE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctrl_q <= RST;
    else if (cfg_wr) ctrl_q <= cfg_wdata & MASK;
  end

  // A match in the same cycle as a clear keeps the flag set.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           alarm_flag <= 1'b0;
    else if (alarm_b_hit) alarm_flag <= 1'b1;
    else if (flag_clr)    alarm_flag <= 1'b0;
  end

endmodule

// File: rtl/pwr_seq.sv
`timescale 1ns/1ps
module pwr_seq
  import pwr_alarm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic off_evt,
  input  logic wake_any,
  output logic pwr_en,
  output logic wake_req
);

  pwr_state_e state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= PWR_ON;
      wake_req <= 1'b0;
    end else begin
      wake_req <= 1'b0;
      unique case (state)
        PWR_ON:  if (off_evt) state <= PWR_OFF;
        PWR_OFF: if (wake_any) begin
          state    <= PWR_ON;
          wake_req <= 1'b1;
        end
        default: state <= PWR_ON;
      endcase
    end
  end

  assign pwr_en = (state == PWR_ON);

endmodule

// File: rtl/pwr_alarm_seq.sv
`timescale 1ns/1ps
module pwr_alarm_seq
  import pwr_alarm_pkg::*;
#(
  parameter int N_WAKE      = 4,   // 1..8, polarity bits must stay below bit 16
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              alarm_b_clr,
  input  logic              alarm_b_hit,
  input  logic              alarm_b_ie,
  input  logic [N_WAKE-1:0] wake_in,
  output logic              pwr_en_o,
  output logic              wake_req_o,
  output logic              alarm_b_flag_o,
  output logic              alarm_b_irq_o
);

  localparam int POL_LSB = N_WAKE;

  // Per-line activity: enabled and at the configured level (pol set = active-low).
  function automatic logic [N_WAKE-1:0] wake_hits(input logic [N_WAKE-1:0] lvl,
                                                  input logic [N_WAKE-1:0] en,
                                                  input logic [N_WAKE-1:0] pol_low);
    logic [N_WAKE-1:0] h;
    for (int i = 0; i < N_WAKE; i++) h[i] = en[i] && (pol_low[i] ? !lvl[i] : lvl[i]);
    return h;
  endfunction

  logic [CTRL_W-1:0] ctrl_q;
  logic              alarm_flag;
  logic [N_WAKE-1:0] wake_lvl;
  logic [N_WAKE-1:0] wake_hit;
  logic              wake_any;
  logic              pwr_ctl_en;
  logic              off_evt;

  pwr_ctrl_regs #(.N_WAKE(N_WAKE)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .cfg_wdata  (cfg_wdata),
    .alarm_b_hit(alarm_b_hit),
    .flag_clr   (alarm_b_clr),
    .ctrl_q     (ctrl_q),
    .alarm_flag (alarm_flag)
  );

  pwr_wake_sync #(.N_WAKE(N_WAKE), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .wake_async(wake_in),
    .wake_sync (wake_lvl)
  );

  assign wake_hit   = wake_hits(wake_lvl, ctrl_q[N_WAKE-1:0], ctrl_q[POL_LSB +: N_WAKE]);
  assign wake_any   = |wake_hit;
  assign pwr_ctl_en = ctrl_q[PWR_CTL_BIT];
  assign off_evt    = alarm_b_hit && pwr_ctl_en;

  pwr_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .off_evt (off_evt),
    .wake_any(wake_any),
    .pwr_en  (pwr_en_o),
    .wake_req(wake_req_o)
  );

  assign cfg_rdata      = ctrl_q;
  assign alarm_b_flag_o = alarm_flag;
  assign alarm_b_irq_o  = alarm_flag && alarm_b_ie;

endmodule

// File: rtl/pwr_alarm_seq_chk.sv
`timescale 1ns/1ps
module pwr_alarm_seq_chk
  import pwr_alarm_pkg::*;
#(
  parameter int N_WAKE = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr,
  input logic [CTRL_W-1:0] cfg_wdata,
  input logic [CTRL_W-1:0] cfg_rdata,
  input logic              alarm_b_hit,
  input logic              alarm_b_clr,
  input logic              pwr_ctl_en,
  input logic              pwr_en_o,
  input logic              wake_req_o,
  input logic              alarm_b_flag_o
);

  localparam logic [CTRL_W-1:0] MASK = ctrl_mask(N_WAKE);

  assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (cfg_rdata == ($past(cfg_wdata) & MASK)));

  assert_alarm_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_b_hit && pwr_ctl_en && pwr_en_o) |=> !pwr_en_o);

  assert_off_needs_ctl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_en_o) |-> $past(alarm_b_hit && pwr_ctl_en));

  assert_flag_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_b_hit |=> alarm_b_flag_o);

  assert_flag_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_b_clr && !alarm_b_hit) |=> !alarm_b_flag_o);

  assert_wake_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req_o |=> !wake_req_o);

  assert_rise_has_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_en_o) |-> wake_req_o);

  assert_no_req_when_on_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req_o |-> $past(!pwr_en_o));

endmodule

bind pwr_alarm_seq pwr_alarm_seq_chk #(.N_WAKE(N_WAKE)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_wr        (cfg_wr),
  .cfg_wdata     (cfg_wdata),
  .cfg_rdata     (cfg_rdata),
  .alarm_b_hit   (alarm_b_hit),
  .alarm_b_clr   (alarm_b_clr),
  .pwr_ctl_en    (pwr_ctl_en),
  .pwr_en_o      (pwr_en_o),
  .wake_req_o    (wake_req_o),
  .alarm_b_flag_o(alarm_b_flag_o)
);

// File: tb/test_pwr_alarm_seq.sv
`timescale 1ns/1ps
module test_pwr_alarm_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        alarm_b_clr = 1'b0;
  logic        alarm_b_hit = 1'b0;
  logic        alarm_b_ie = 1'b0;
  logic [3:0]  wake_in = '0;
  logic        pwr_en_o, wake_req_o, alarm_b_flag_o, alarm_b_irq_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwr_alarm_seq i_pwr_alarm_seq (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .alarm_b_clr(alarm_b_clr), .alarm_b_hit(alarm_b_hit),
    .alarm_b_ie(alarm_b_ie), .wake_in(wake_in), .pwr_en_o(pwr_en_o),
    .wake_req_o(wake_req_o), .alarm_b_flag_o(alarm_b_flag_o),
    .alarm_b_irq_o(alarm_b_irq_o)
  );

  // {enable[3:0], polarity[3:0], wake pattern[3:0], power expected back on}
  localparam logic [12:0] VEC [8] = '{
    {4'b0001, 4'b1111, 4'b1110, 1'b1},  // line 0 active-low, driven low
    {4'b0001, 4'b1111, 4'b1111, 1'b0},  // line 0 active-low, held high
    {4'b0010, 4'b0000, 4'b0010, 1'b1},  // line 1 active-high, driven high
    {4'b0100, 4'b1111, 4'b0000, 1'b1},  // line 2 active-low, all low
    {4'b0000, 4'b1111, 4'b0000, 1'b0},  // all lines disabled
    {4'b1000, 4'b0111, 4'b1000, 1'b1},  // line 3 active-high
    {4'b1000, 4'b1111, 4'b1000, 1'b0},  // line 3 active-low, high level
    {4'b0110, 4'b0100, 4'b0001, 1'b1}   // line 2 low with active-low wins
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cfg_wr = 1'b0; alarm_b_hit = 1'b0; alarm_b_clr = 1'b0;
    alarm_b_ie = 1'b0; wake_in = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic write_ctrl(input logic [31:0] v);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic pulse_alarm();
    @(negedge clk);
    alarm_b_hit = 1'b1;
    @(negedge clk);
    alarm_b_hit = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R1..R9 run hung: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    do_reset();
    check("R1", "pwr_en", {31'd0, pwr_en_o}, 32'd1);
    check("R1", "wake_req", {31'd0, wake_req_o}, 32'd0);
    check("R1", "flag", {31'd0, alarm_b_flag_o}, 32'd0);
    check("R1", "irq", {31'd0, alarm_b_irq_o}, 32'd0);
    check("R1", "ctrl", cfg_rdata, 32'h0000_00F0);

    // R2 writable bits only
    write_ctrl(32'hFFFF_FFFF);
    check("R2", "ctrl all ones", cfg_rdata, 32'h0001_00FF);
    write_ctrl(32'h0000_0000);
    check("R2", "ctrl zero", cfg_rdata, 32'h0000_0000);

    // R4 alarm with power control clear; R5 flag; R6 interrupt gating
    pulse_alarm();
    check("R4", "pwr_en kept", {31'd0, pwr_en_o}, 32'd1);
    check("R5", "flag set", {31'd0, alarm_b_flag_o}, 32'd1);
    check("R6", "irq masked", {31'd0, alarm_b_irq_o}, 32'd0);
    @(negedge clk); alarm_b_ie = 1'b1; #1;
    check("R6", "irq enabled", {31'd0, alarm_b_irq_o}, 32'd1);
    repeat (4) @(negedge clk);
    check("R5", "flag sticky", {31'd0, alarm_b_flag_o}, 32'd1);
    check("R4", "pwr_en still on", {31'd0, pwr_en_o}, 32'd1);
    // R5 match and clear together: set wins
    @(negedge clk); alarm_b_hit = 1'b1; alarm_b_clr = 1'b1;
    @(negedge clk); alarm_b_hit = 1'b0; alarm_b_clr = 1'b0;
    check("R5", "set beats clear", {31'd0, alarm_b_flag_o}, 32'd1);
    @(negedge clk); alarm_b_clr = 1'b1;
    @(negedge clk); alarm_b_clr = 1'b0;
    check("R5", "flag cleared", {31'd0, alarm_b_flag_o}, 32'd0);
    check("R6", "irq follows flag", {31'd0, alarm_b_irq_o}, 32'd0);

    // R3 / R7 / R8 table walk
    foreach (VEC[k]) begin
      logic [3:0] en, pol, pat;
      logic       exp;
      {en, pol, pat, exp} = VEC[k];
      do_reset();
      wake_in = pol;  // idle level for every line
      write_ctrl(32'h0001_0000 | {24'd0, pol, en});
      repeat (3) @(negedge clk);
      pulse_alarm();
      check("R3", $sformatf("vec%0d pwr off", k), {31'd0, pwr_en_o}, 32'd0);
      @(negedge clk); wake_in = pat;
      repeat (3) @(negedge clk);
      check(exp ? "R7" : "R8", $sformatf("vec%0d pwr_en", k), {31'd0, pwr_en_o}, {31'd0, exp});
      check(exp ? "R7" : "R8", $sformatf("vec%0d wake_req", k), {31'd0, wake_req_o}, {31'd0, exp});
      @(negedge clk);
      check("R7", $sformatf("vec%0d req drop", k), {31'd0, wake_req_o}, 32'd0);
      check(exp ? "R7" : "R8", $sformatf("vec%0d pwr hold", k), {31'd0, pwr_en_o}, {31'd0, exp});
    end

    // R9 active wake line while power is on
    do_reset();
    write_ctrl(32'h0001_00F1);  // line 0 enabled, active-low, power control on
    @(negedge clk); wake_in = 4'b0000;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      check("R9", $sformatf("cycle%0d wake_req", c), {31'd0, wake_req_o}, 32'd0);
      check("R9", $sformatf("cycle%0d pwr_en", c), {31'd0, pwr_en_o}, 32'd1);
    end
    // R7 wake still held when the alarm turns power off: back on one edge later
    pulse_alarm();
    check("R3", "held wake pwr off", {31'd0, pwr_en_o}, 32'd0);
    @(negedge clk);
    check("R7", "held wake pwr back", {31'd0, pwr_en_o}, 32'd1);
    check("R7", "held wake pulse", {31'd0, wake_req_o}, 32'd1);
    @(negedge clk);
    check("R7", "held wake pulse ends", {31'd0, wake_req_o}, 32'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule